// File: doc/BRIEF.md
# Default-Master Bus Arbiter

This block decides who drives a shared bus that has one primary master and a parameterised number of secondary masters. The primary master is the parking owner: whenever no secondary is asking for the bus, the primary holds the grant and uses every idle cycle. A secondary gets the bus by raising its request line. The primary hands over only at the end of its current bus cycle, which it signals by lowering its busy input.

Once a secondary is granted, it keeps the bus for as long as its request stays high. Nothing preempts it, whether the primary or other secondaries. When it lowers its request, the arbiter leaves one cycle with no grant on the bus. It then serves the next pending secondary or returns the bus to the primary.

When several secondaries ask at the same moment, a rotating pointer picks the winner. The search starts just past the secondary served last, so no requester can be locked out.

Top module: `dmBusArbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `primGnt` is 1 and `secGnt` is all zeros.
- R2: With no secondary request, `primGnt` stays 1 on every cycle.
- R3: While `primBusy` is 1, the primary keeps its grant even if secondary requests are pending. A handover is never made during a primary bus cycle.
- R4: Suppose the primary owns the bus and a clock edge samples at least one request with `primBusy` at 0. After that edge, `primGnt` is 0 and exactly the winning secondary's bit of `secGnt` is 1. Bit i of `secGnt` belongs to secondary i, the same as bit i of `secReq`.
- R5: A granted secondary's grant stays unchanged for as long as its own request stays 1, whatever the other requests and `primBusy` do.
- R6: When the owning secondary's request is sampled at 0, all grants (`primGnt` included) are 0 for exactly one cycle.
- R7: After that idle cycle, the bus goes to a pending secondary if any request is sampled. Otherwise `primGnt` returns to 1.
- R8: Among simultaneous requests, the winner is the first requesting index found by searching upward from one past the last served secondary, wrapping from NUM_SEC-1 to 0. After reset the search starts at index 0.
- R9: At most one of the NUM_SEC+1 grant outputs is 1 on any cycle.
- R10: A request withdrawn before it is granted has no effect: `primGnt` stays 1 and no `secGnt` bit rises.
- R11: A secondary is granted only if its request was 1 at the clock edge that issued the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| secReq | input | NUM_SEC | Request line per secondary master |
| primBusy | input | 1 | High while the primary is inside a bus cycle |
| secGnt | output | NUM_SEC | Registered grant per secondary master |
| primGnt | output | 1 | Registered grant to the primary master |

## Verification
The handover is first tried with a single request held while the primary is busy. This separates a design that waits for the end of the cycle from one that grants at once.

All secondaries then request together while one of them owns the bus. This exposes any preemption.

A chain of releases follows, each with a different mix of pending requests: indices above the last served, a wrap back to index 0, and a request from the primary-owned state after earlier service. This tells a rotating search apart from fixed priority, and a search with the pointer updated from one without. Finally, a request is raised and withdrawn under a busy primary, which separates the correct behaviour from a design that latches stale requests.

// File: rtl/arbPkg.sv
package arbPkg;

  typedef enum logic [1:0] {
    ST_PRIM = 2'd0,
    ST_SEC  = 2'd1,
    ST_DEAD = 2'd2
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeWinner;  // latch the picked secondary as owner and grant it
    logic dropSec;     // clear every secondary grant
    logic primOn;      // grant the primary
    logic primOff;     // remove the primary grant
  } arbStrobe_t;

endpackage

// File: rtl/rrPicker.sv
module rrPicker #(
  parameter int NUM_SEC = 4,
  localparam int IDX_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic [NUM_SEC-1:0] reqVec,
  input  logic [IDX_W-1:0]   lastIdx,
  output logic [IDX_W-1:0]   winIdx,
  output logic               winValid
);

  always_comb begin
    int idx;
    winIdx   = '0;
    winValid = 1'b0;
    idx      = 0;
    for (int k = 1; k <= NUM_SEC; k++) begin
      idx = int'(lastIdx) + k;
      if (idx >= NUM_SEC) idx = idx - NUM_SEC;
      if (!winValid && reqVec[idx]) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(idx);
      end
    end
  end

endmodule

// File: rtl/arbPath.sv
module arbPath
  import arbPkg::*;
#(
  parameter int NUM_SEC = 4,
  localparam int IDX_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEC-1:0] secReq,
  input  arbStrobe_t         strobe,
  output logic               anyReq,
  output logic               ownerReq,
  output logic [NUM_SEC-1:0] secGnt,
  output logic               primGnt
);

  logic [IDX_W-1:0] ownerIdx;
  logic [IDX_W-1:0] lastServed;
  logic [IDX_W-1:0] winIdx;
  logic             winValid;

  rrPicker #(.NUM_SEC(NUM_SEC)) picker (
    .reqVec  (secReq),
    .lastIdx (lastServed),
    .winIdx  (winIdx),
    .winValid(winValid)
  );

  assign anyReq   = winValid;
  assign ownerReq = secReq[ownerIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerIdx   <= '0;
      lastServed <= IDX_W'(NUM_SEC - 1);
      primGnt    <= 1'b1;
    end else begin
      if (strobe.takeWinner) begin
        ownerIdx   <= winIdx;
        lastServed <= winIdx;
      end
      if (strobe.primOn)       primGnt <= 1'b1;
      else if (strobe.primOff) primGnt <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_SEC; g++) begin : gntBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     secGnt[g] <= 1'b0;
      else if (strobe.takeWinner)                    secGnt[g] <= (winIdx == IDX_W'(g));
      else if (strobe.dropSec)                       secGnt[g] <= 1'b0;
    end

    // R5
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
      (secGnt[g] && secReq[g]) |=> secGnt[g]);

    // R11
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(secGnt[g]) |-> $past(secReq[g]));
  end

  // R9
  one_hot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({secGnt, primGnt}));

  // R6
  dead_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|secGnt) && !(|(secGnt & secReq))) |=> (secGnt == '0 && !primGnt));

endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       ownerReq,
  input  logic       primBusy,
  output arbStrobe_t strobe
);

  arbState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_PRIM: begin
        if (anyReq && !primBusy) begin
          strobe.takeWinner = 1'b1;
          strobe.primOff    = 1'b1;
          nextState         = ST_SEC;
        end
      end
      ST_SEC: begin
        if (!ownerReq) begin
          strobe.dropSec = 1'b1;
          nextState      = ST_DEAD;
        end
      end
      ST_DEAD: begin
        if (anyReq) begin
          strobe.takeWinner = 1'b1;
          nextState         = ST_SEC;
        end else begin
          strobe.primOn = 1'b1;
          nextState     = ST_PRIM;
        end
      end
      default: nextState = ST_PRIM;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PRIM;
    else       state <= nextState;
  end

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRIM && primBusy) |=> (state == ST_PRIM));

  // R7
  dead_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEAD) |=> (state != ST_DEAD));

endmodule

// File: rtl/dmBusArbiter.sv
module dmBusArbiter
  import arbPkg::*;
#(
  parameter int NUM_SEC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEC-1:0] secReq,
  input  logic               primBusy,
  output logic [NUM_SEC-1:0] secGnt,
  output logic               primGnt
);

  arbStrobe_t strobe;
  logic       anyReq;
  logic       ownerReq;

  arbCtrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .anyReq  (anyReq),
    .ownerReq(ownerReq),
    .primBusy(primBusy),
    .strobe  (strobe)
  );

  arbPath #(.NUM_SEC(NUM_SEC)) path (
    .clk     (clk),
    .rstN    (rstN),
    .secReq  (secReq),
    .strobe  (strobe),
    .anyReq  (anyReq),
    .ownerReq(ownerReq),
    .secGnt  (secGnt),
    .primGnt (primGnt)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (primGnt && secGnt == '0));

  // R2
  idle_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primGnt && secReq == '0) |=> primGnt);

endmodule

// File: tb/dmBusArbiter_test.sv
module dmBusArbiter_test;

  localparam int N = 4;

  typedef struct {
    logic [N-1:0] sec;
    logic         prim;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] secReq = '0;
  logic         primBusy = 1'b0;
  logic [N-1:0] secGnt;
  logic         primGnt;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  expItem_t q[$];

  dmBusArbiter #(.NUM_SEC(N)) uut (
    .clk(clk), .rstN(rstN), .secReq(secReq), .primBusy(primBusy),
    .secGnt(secGnt), .primGnt(primGnt)
  );

  always #5 clk = ~clk;

  // driver: inputs for one cycle plus outputs expected after the edge
  task automatic step(input logic [N-1:0] req, input logic busy,
                      input logic [N-1:0] expSec, input logic expPrim,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    secReq   = req;
    primBusy = busy;
    it.sec  = expSec;
    it.prim = expPrim;
    it.tag  = tag;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        expItem_t it;
        it = q.pop_front();
        compared++;
        if (secGnt !== it.sec || primGnt !== it.prim) begin
          mismatched++;
          $display("FAIL %s: got sec=%b prim=%b, expected sec=%b prim=%b",
                   it.tag, secGnt, primGnt, it.sec, it.prim);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    compared++;
    if (primGnt !== 1'b1 || secGnt !== '0) begin
      mismatched++;
      $display("FAIL R1: got sec=%b prim=%b, expected sec=0000 prim=1", secGnt, primGnt);
    end
    rstN = 1'b1;

    // R1 / R2 idle parking
    step(4'b0000, 1'b0, 4'b0000, 1'b1, "R1 first cycle");
    step(4'b0000, 1'b1, 4'b0000, 1'b1, "R2 idle");
    step(4'b0000, 1'b0, 4'b0000, 1'b1, "R2 idle");
    // R3 busy primary holds
    step(4'b0001, 1'b1, 4'b0000, 1'b1, "R3 busy hold");
    step(4'b0001, 1'b1, 4'b0000, 1'b1, "R3 busy hold");
    // R4 handover
    step(4'b0001, 1'b0, 4'b0001, 1'b0, "R4 handover");
    // R5 no preemption
    step(4'b1111, 1'b1, 4'b0001, 1'b0, "R5 no preempt");
    step(4'b1111, 1'b0, 4'b0001, 1'b0, "R5 no preempt");
    // R6 release, R8 next after 0 is 1
    step(4'b1110, 1'b0, 4'b0000, 1'b0, "R6 dead cycle");
    step(4'b1110, 1'b0, 4'b0010, 1'b0, "R8 rotate to 1");
    step(4'b1100, 1'b0, 4'b0000, 1'b0, "R6 dead cycle");
    step(4'b1100, 1'b0, 4'b0100, 1'b0, "R8 rotate to 2");
    step(4'b1001, 1'b0, 4'b0000, 1'b0, "R6 dead cycle");
    step(4'b1001, 1'b0, 4'b1000, 1'b0, "R8 rotate to 3");
    step(4'b0001, 1'b0, 4'b0000, 1'b0, "R6 dead cycle");
    step(4'b0001, 1'b0, 4'b0001, 1'b0, "R8 wrap to 0");
    step(4'b0000, 1'b0, 4'b0000, 1'b0, "R6 dead cycle");
    step(4'b0000, 1'b0, 4'b0000, 1'b1, "R7 back to primary");
    // R10 withdrawn request
    step(4'b0100, 1'b1, 4'b0000, 1'b1, "R10 req while busy");
    step(4'b0000, 1'b0, 4'b0000, 1'b1, "R10 withdrawn");
    step(4'b0000, 1'b0, 4'b0000, 1'b1, "R10 withdrawn");
    // R8 from primary: last served 0, so 2 wins over 0
    step(4'b0101, 1'b0, 4'b0100, 1'b0, "R8 from primary");
    step(4'b0001, 1'b0, 4'b0000, 1'b0, "R6 dead cycle");
    step(4'b0001, 1'b0, 4'b0001, 1'b0, "R7 pending served");
    step(4'b0000, 1'b1, 4'b0000, 1'b0, "R6 dead cycle");
    step(4'b0000, 1'b1, 4'b0000, 1'b1, "R7 back to primary");
    step(4'b0000, 1'b0, 4'b0000, 1'b1, "R9 single owner");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule